// File: doc/BRIEF.md
# Memory-Mapped GPIO Controller with Per-Pin Function Select

This block gives software control of a row of general-purpose pads through a small word-addressed register bus with separate write and read strobes. Three register banks hold, for every pin, an output level, a drive direction and a function-select flag. Each bank is spread over several consecutive words, and only the low byte of each word holds pin bits.

A pin whose function-select flag is clear is under software control. Its pad output comes from the stored level, and its output enable comes from the direction flag. A pin whose flag is set hands both pad signals to the peripheral-side inputs. The software latches keep their values in that case, so switching the pin back restores the earlier state. The stored level can be preloaded while the pin is still an input, so the pin drives the right value on the first cycle that it turns into an output. Reading the level bank returns the stored level for output pins, and for input pins it returns the pad input after a two-stage synchroniser.

Top module: `gpio_mux_ctrl`

## Requirements
- R1: Pin n belongs to word n/8 of each bank, at bit n mod 8. Word addresses 0 to 3 select the level bank, 4 to 7 the direction bank, and 8 to 11 the function-select bank. These are byte offsets 0x00, 0x10 and 0x20 divided by four.
- R2: A write with `wr_en` high updates bits 7:0 of the addressed word on the clock edge that samples it. Bits 31:8 of `wdata` are discarded. A write to word address 12 to 15 changes no bank.
- R3: A read strobe sampled on an edge makes `rvalid` high for the following cycle, with `rdata` holding the word. Bits 31:8 of `rdata` are zero, and reads of word addresses 12 to 15 return zero. While `rvalid` is low, `rdata` is zero.
- R4: After reset every function-select bit is 1, every direction bit is 0 and every level bit is 0, so `pad_out` equals `alt_out` and `pad_oe` equals `alt_oe`.
- R5: A pin with function-select 0 and direction 1 has `pad_oe` high and `pad_out` equal to its stored level.
- R6: A pin with function-select 0 and direction 0 has `pad_oe` low, and `pad_out` still shows its stored level.
- R7: A pin with function-select 1 takes `pad_out` and `pad_oe` from `alt_out` and `alt_oe`. Its level and direction bits keep their values and read back unchanged.
- R8: Reading the level bank returns, for each pin, the stored level when its direction is 1, and otherwise the synchronised pad input. A `pad_in` level driven before edge k is returned by a read strobe sampled on edge k+2 but not by one sampled on edge k+1. The function-select bit has no effect on this choice.
- R9: A level written while the pin is an input appears on `pad_out` in the same cycle that a later direction write raises `pad_oe`.
- R10: When a read and a write to the same address are sampled on the same edge, the read returns the value the word held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 4 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| rvalid | output | 1 | Read data valid |
| pad_in | input | 32 | Pad input levels, asynchronous |
| pad_out | output | 32 | Pad output levels |
| pad_oe | output | 32 | Pad output enables |
| alt_out | input | 32 | Peripheral-side output levels |
| alt_oe | input | 32 | Peripheral-side output enables |

## Verification
The hardest situation to reach from the ports is the two-edge synchroniser latency on input readback. The bench changes `pad_in` on a falling edge and then issues back-to-back reads of the same level word. The first read must still return the old level and the second must return the new one. The preload path also needs a set sequence: the pin is handed to software control, its level is written while it is still an input, and its direction is written on the next cycle, so the bench can check that `pad_out` already holds the new level when `pad_oe` rises. A behavioural model tracks every register and the synchroniser, and it is compared with the pads and the read port on every cycle, including a long stretch of random bus traffic with changing peripheral inputs.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;

   // Register bank selected by a word address.
   typedef enum logic [1:0] {
      BK_LEVEL = 2'd0,
      BK_DIR   = 2'd1,
      BK_FSEL  = 2'd2,
      BK_NONE  = 2'd3
   } bank_e;

   localparam int NUM_BANKS = 3;

   // Width of a word index inside a bank, at least one bit.
   function automatic int idx_width(input int words);
      return (words > 1) ? $clog2(words) : 1;
   endfunction

endpackage

// File: rtl/gpio_mux_decode.sv
module gpio_mux_decode
   import gpio_mux_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int STRIDE = 4,
   parameter int WORDS  = 4,
   localparam int WIDX  = idx_width(WORDS)
) (
   input  logic [ADDR_W-1:0] addr,
   output bank_e             bank,
   output logic [WIDX-1:0]   word
);

   int a_i;
   int bnum;
   int wnum;

   always_comb begin
      a_i  = int'(addr);
      bnum = a_i / STRIDE;
      wnum = a_i % STRIDE;
      word = WIDX'(wnum);
      if (wnum >= WORDS) begin
         bank = BK_NONE;
      end else begin
         case (bnum)
            0:       bank = BK_LEVEL;
            1:       bank = BK_DIR;
            2:       bank = BK_FSEL;
            default: bank = BK_NONE;
         endcase
      end
   end

endmodule

// File: rtl/gpio_mux_bank.sv
module gpio_mux_bank
   import gpio_mux_pkg::*;
#(
   parameter int   NUM_PINS = 32,
   parameter int   PPW      = 8,
   parameter logic RST_BIT  = 1'b0,
   localparam int  WORDS    = NUM_PINS / PPW,
   localparam int  WIDX     = idx_width(WORDS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr,
   input  logic [WIDX-1:0]     word,
   input  logic [PPW-1:0]      wbyte,
   output logic [NUM_PINS-1:0] q
);

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      logic [PPW-1:0] r;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            r <= {PPW{RST_BIT}};
         end else if (wr && (word == WIDX'(w))) begin
            r <= wbyte;
         end
      end

      assign q[w*PPW +: PPW] = r;
   end

endmodule

// File: rtl/gpio_mux_sync.sv
module gpio_mux_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   logic [WIDTH-1:0] st [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) begin
            st[s] <= '0;
         end
      end else begin
         st[0] <= din;
         for (int s = 1; s < STAGES; s++) begin
            st[s] <= st[s-1];
         end
      end
   end

   assign dout = st[STAGES-1];

endmodule

// File: rtl/gpio_mux_pad.sv
module gpio_mux_pad #(
   parameter int NUM_PINS = 32
) (
   input  logic [NUM_PINS-1:0] level_q,
   input  logic [NUM_PINS-1:0] dir_q,
   input  logic [NUM_PINS-1:0] fsel_q,
   input  logic [NUM_PINS-1:0] sync_in,
   input  logic [NUM_PINS-1:0] alt_out,
   input  logic [NUM_PINS-1:0] alt_oe,
   output logic [NUM_PINS-1:0] pad_out,
   output logic [NUM_PINS-1:0] pad_oe,
   output logic [NUM_PINS-1:0] level_view
);

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      // The level latch feeds the pad even while the pin is an input, so
      // raising the direction bit never shows a stale level.
      assign pad_out[i]    = fsel_q[i] ? alt_out[i] : level_q[i];
      assign pad_oe[i]     = fsel_q[i] ? alt_oe[i]  : dir_q[i];
      assign level_view[i] = dir_q[i]  ? level_q[i] : sync_in[i];
   end

endmodule

// File: rtl/gpio_mux_rdback.sv
module gpio_mux_rdback
   import gpio_mux_pkg::*;
#(
   parameter int  NUM_PINS = 32,
   parameter int  PPW      = 8,
   parameter int  DATA_W   = 32,
   localparam int WORDS    = NUM_PINS / PPW,
   localparam int WIDX     = idx_width(WORDS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rd,
   input  bank_e               bank,
   input  logic [WIDX-1:0]     word,
   input  logic [NUM_PINS-1:0] level_view,
   input  logic [NUM_PINS-1:0] dir_q,
   input  logic [NUM_PINS-1:0] fsel_q,
   output logic [DATA_W-1:0]   rdata,
   output logic                rvalid
);

   logic [NUM_PINS-1:0] vec;
   logic [PPW-1:0]      slice;
   int                  base;

   always_comb begin
      case (bank)
         BK_LEVEL: vec = level_view;
         BK_DIR:   vec = dir_q;
         BK_FSEL:  vec = fsel_q;
         default:  vec = '0;
      endcase
      base  = int'(word) * PPW;
      slice = vec[base +: PPW];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rvalid <= 1'b0;
         rdata  <= '0;
      end else begin
         rvalid <= rd;
         rdata  <= rd ? DATA_W'(slice) : '0;
      end
   end

endmodule

// File: rtl/gpio_mux_ctrl.sv
module gpio_mux_ctrl
   import gpio_mux_pkg::*;
#(
   parameter int  NUM_PINS      = 32,
   parameter int  PINS_PER_WORD = 8,
   parameter int  DATA_W        = 32,
   parameter int  ADDR_W        = 4,
   parameter int  BANK_STRIDE   = 4,
   parameter int  SYNC_STAGES   = 2,
   localparam int WORDS         = NUM_PINS / PINS_PER_WORD,
   localparam int WIDX          = idx_width(WORDS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic                rd_en,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [DATA_W-1:0]   wdata,
   output logic [DATA_W-1:0]   rdata,
   output logic                rvalid,
   input  logic [NUM_PINS-1:0] pad_in,
   output logic [NUM_PINS-1:0] pad_out,
   output logic [NUM_PINS-1:0] pad_oe,
   input  logic [NUM_PINS-1:0] alt_out,
   input  logic [NUM_PINS-1:0] alt_oe
);

   // Elaboration-time parameter checks.
   if (NUM_PINS % PINS_PER_WORD != 0) begin : g_chk_pins
      $error("NUM_PINS must be a multiple of PINS_PER_WORD");
   end
   if (PINS_PER_WORD >= DATA_W) begin : g_chk_ppw
      $error("PINS_PER_WORD must be narrower than DATA_W");
   end
   if (WORDS > BANK_STRIDE) begin : g_chk_stride
      $error("a bank does not fit in BANK_STRIDE words");
   end
   if (NUM_BANKS * BANK_STRIDE > (1 << ADDR_W)) begin : g_chk_addr
      $error("ADDR_W too narrow for all banks");
   end
   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("SYNC_STAGES must be at least 2");
   end

   bank_e               bank;
   logic [WIDX-1:0]     word;
   logic [NUM_PINS-1:0] bank_q [NUM_BANKS];
   logic [NUM_PINS-1:0] level_q;
   logic [NUM_PINS-1:0] dir_q;
   logic [NUM_PINS-1:0] fsel_q;
   logic [NUM_PINS-1:0] sync_in;
   logic [NUM_PINS-1:0] level_view;

   gpio_mux_decode #(
      .ADDR_W (ADDR_W),
      .STRIDE (BANK_STRIDE),
      .WORDS  (WORDS)
   ) u_decode (
      .addr (addr),
      .bank (bank),
      .word (word)
   );

   // One bank per register kind; the function-select bank resets to ones.
   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic wr_b;
      assign wr_b = wr_en && (bank == bank_e'(b));

      gpio_mux_bank #(
         .NUM_PINS (NUM_PINS),
         .PPW      (PINS_PER_WORD),
         .RST_BIT  ((b == int'(BK_FSEL)) ? 1'b1 : 1'b0)
      ) u_bank (
         .clk   (clk),
         .rst_n (rst_n),
         .wr    (wr_b),
         .word  (word),
         .wbyte (wdata[PINS_PER_WORD-1:0]),
         .q     (bank_q[b])
      );
   end

   assign level_q = bank_q[int'(BK_LEVEL)];
   assign dir_q   = bank_q[int'(BK_DIR)];
   assign fsel_q  = bank_q[int'(BK_FSEL)];

   gpio_mux_sync #(
      .WIDTH  (NUM_PINS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (pad_in),
      .dout  (sync_in)
   );

   gpio_mux_pad #(
      .NUM_PINS (NUM_PINS)
   ) u_pad (
      .level_q    (level_q),
      .dir_q      (dir_q),
      .fsel_q     (fsel_q),
      .sync_in    (sync_in),
      .alt_out    (alt_out),
      .alt_oe     (alt_oe),
      .pad_out    (pad_out),
      .pad_oe     (pad_oe),
      .level_view (level_view)
   );

   gpio_mux_rdback #(
      .NUM_PINS (NUM_PINS),
      .PPW      (PINS_PER_WORD),
      .DATA_W   (DATA_W)
   ) u_rdback (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd         (rd_en),
      .bank       (bank),
      .word       (word),
      .level_view (level_view),
      .dir_q      (dir_q),
      .fsel_q     (fsel_q),
      .rdata      (rdata),
      .rvalid     (rvalid)
   );

endmodule

// File: rtl/gpio_mux_chk.sv
module gpio_mux_chk #(
   parameter int  NUM_PINS      = 32,
   parameter int  PINS_PER_WORD = 8,
   parameter int  DATA_W        = 32,
   parameter int  ADDR_W        = 4,
   parameter int  BANK_STRIDE   = 4,
   localparam int WORDS         = NUM_PINS / PINS_PER_WORD
) (
   input logic                clk,
   input logic                rst_n,
   input logic                wr_en,
   input logic                rd_en,
   input logic [ADDR_W-1:0]   addr,
   input logic [DATA_W-1:0]   wdata,
   input logic [DATA_W-1:0]   rdata,
   input logic                rvalid,
   input logic [NUM_PINS-1:0] level_q,
   input logic [NUM_PINS-1:0] dir_q,
   input logic [NUM_PINS-1:0] fsel_q
);

   localparam int PPW = PINS_PER_WORD;

   for (genvar w = 0; w < WORDS; w++) begin : g_w
      AST_LEVEL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && addr == ADDR_W'(w)) |=> level_q[w*PPW +: PPW] == $past(wdata[PPW-1:0])); // R2
      AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && addr == ADDR_W'(BANK_STRIDE + w)) |=> dir_q[w*PPW +: PPW] == $past(wdata[PPW-1:0])); // R1
      AST_FSEL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && addr == ADDR_W'(2*BANK_STRIDE + w)) |=> fsel_q[w*PPW +: PPW] == $past(wdata[PPW-1:0])); // R1
   end

   AST_NO_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(level_q) && $stable(dir_q) && $stable(fsel_q))); // R2
   AST_RVALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rvalid); // R3
   AST_RVALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !rvalid); // R3
   AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rvalid |-> rdata[DATA_W-1:PPW] == '0); // R3
   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !rvalid |-> rdata == '0); // R3

endmodule

bind gpio_mux_ctrl gpio_mux_chk #(
   .NUM_PINS      (NUM_PINS),
   .PINS_PER_WORD (PINS_PER_WORD),
   .DATA_W        (DATA_W),
   .ADDR_W        (ADDR_W),
   .BANK_STRIDE   (BANK_STRIDE)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .rd_en   (rd_en),
   .addr    (addr),
   .wdata   (wdata),
   .rdata   (rdata),
   .rvalid  (rvalid),
   .level_q (level_q),
   .dir_q   (dir_q),
   .fsel_q  (fsel_q)
);

// File: tb/gpio_mux_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_mux_ctrl_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        rvalid;
   logic [31:0] pad_in = '0;
   logic [31:0] pad_out;
   logic [31:0] pad_oe;
   logic [31:0] alt_out = 32'h3C5A_96E1;
   logic [31:0] alt_oe  = 32'hA5A5_0FF0;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;

   gpio_mux_ctrl u_gpio_mux_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .rd_en   (rd_en),
      .addr    (addr),
      .wdata   (wdata),
      .rdata   (rdata),
      .rvalid  (rvalid),
      .pad_in  (pad_in),
      .pad_out (pad_out),
      .pad_oe  (pad_oe),
      .alt_out (alt_out),
      .alt_oe  (alt_oe)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic [31:0] m_lvl, m_dir, m_fsel, m_s1, m_s2, m_rdata;
   logic        m_rvalid;

   function automatic logic [31:0] m_read(input int a);
      logic [31:0] v;
      v = (m_dir & m_lvl) | (~m_dir & m_s2);
      if (a < 4)       return {24'h0, v[a*8 +: 8]};
      else if (a < 8)  return {24'h0, m_dir[(a-4)*8 +: 8]};
      else if (a < 12) return {24'h0, m_fsel[(a-8)*8 +: 8]};
      return 32'h0;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_lvl = '0; m_dir = '0; m_fsel = '1; m_s1 = '0; m_s2 = '0;
         m_rdata = '0; m_rvalid = 1'b0;
      end else begin
         m_rvalid = rd_en;
         m_rdata  = rd_en ? m_read(int'(addr)) : 32'h0;
         if (wr_en) begin
            if (addr < 4)       m_lvl[int'(addr)*8 +: 8]        = wdata[7:0];
            else if (addr < 8)  m_dir[(int'(addr)-4)*8 +: 8]    = wdata[7:0];
            else if (addr < 12) m_fsel[(int'(addr)-8)*8 +: 8]   = wdata[7:0];
         end
         m_s2 = m_s1;
         m_s1 = pad_in;
      end
   end

   // Every-cycle comparison, sampled 1 ns after the rising edge.
   always begin
      @(posedge clk);
      #1;
      if (rst_n) begin
         chk("R5/R6/R7 pad_out", pad_out, (m_fsel & alt_out) | (~m_fsel & m_lvl));
         chk("R5/R6/R7 pad_oe",  pad_oe,  (m_fsel & alt_oe)  | (~m_fsel & m_dir));
         chk("R3 rvalid", {31'h0, rvalid}, {31'h0, m_rvalid});
         chk("R8/R10 rdata", rdata, m_rdata);
      end
   end

   // ---------------- bus tasks ----------------
   task automatic do_write(input int a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; rd_en = 1'b0; addr = 4'(a); wdata = d;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic do_read(input int a, output logic [31:0] v);
      @(negedge clk);
      rd_en = 1'b1; wr_en = 1'b0; addr = 4'(a);
      @(posedge clk); #1;
      rd_en = 1'b0;
      v = rdata;
      chk("R3 rvalid after strobe", {31'h0, rvalid}, 32'h1);
   endtask

   task automatic do_rdwr(input int a, input logic [31:0] d, output logic [31:0] v);
      @(negedge clk);
      rd_en = 1'b1; wr_en = 1'b1; addr = 4'(a); wdata = d;
      @(posedge clk); #1;
      rd_en = 1'b0; wr_en = 1'b0;
      v = rdata;
   endtask

   // ---------------- watchdog ----------------
   initial begin
      #(4 * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

   // ---------------- directed and random stimulus ----------------
   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #1;

      // R4: reset values at the pads and through the read port
      chk("R4 pad_out follows alt", pad_out, alt_out);
      chk("R4 pad_oe follows alt", pad_oe, alt_oe);
      chk("R4 idle rdata", rdata, 32'h0);
      for (int w = 0; w < 4; w++) begin
         do_read(8 + w, v);  chk("R4 fsel reset", v, 32'h0000_00FF);
         do_read(4 + w, v);  chk("R4 dir reset", v, 32'h0);
      end

      // Hand words 0 and 1 to software; word 2 half; word 3 stays peripheral
      do_write(8,  32'hFFFF_FF00);
      do_write(9,  32'h0000_0000);
      do_write(10, 32'h0000_000F);
      do_read(8, v); chk("R2 upper write bits dropped", v, 32'h0);

      // R6/R9: preload level while input
      do_write(0, 32'hDEAD_BE5A);
      chk("R6 level visible, not driven", pad_out[7:0], 8'h5A);
      chk("R6 oe low while input", pad_oe[7:0], 8'h00);
      do_write(4, 32'h1234_56FF);
      chk("R9 oe rises", pad_oe[7:0], 8'hFF);
      chk("R9 level on first driven cycle", pad_out[7:0], 8'h5A);
      do_read(0, v); chk("R8 output pin reads latch", v, 32'h0000_005A);
      do_read(4, v); chk("R3 upper bits zero", v, 32'h0000_00FF);

      // R8: synchroniser latency on input word 1
      @(negedge clk); pad_in = 32'h0000_C300;
      do_read(1, v); chk("R8 read on edge k+1 is old", v, 32'h0);
      do_read(1, v); chk("R8 read on edge k+2 is new", v, 32'h0000_00C3);

      // R7: hand word 0 to the peripheral and back; latches retained
      do_write(8, 32'h0000_00FF);
      chk("R7 pad_out from alt", pad_out[7:0], alt_out[7:0]);
      chk("R7 pad_oe from alt", pad_oe[7:0], alt_oe[7:0]);
      do_read(0, v); chk("R7 level kept", v, 32'h0000_005A);
      do_read(4, v); chk("R7 dir kept", v, 32'h0000_00FF);
      do_write(8, 32'h0);
      chk("R7 level restored", pad_out[7:0], 8'h5A);

      // R1: pin 29 is word 3 bit 5
      do_write(11, 32'h0000_00DF);
      do_write(7,  32'h0000_0020);
      do_write(3,  32'h0000_0020);
      chk("R1 pin29 oe", {31'h0, pad_oe[29]}, 32'h1);
      chk("R1 pin29 out", {31'h0, pad_out[29]}, 32'h1);
      chk("R1 other word3 oe from alt", pad_oe[31:24] & 8'hDF, alt_oe[31:24] & 8'hDF);

      // R2/R3: unmapped addresses
      do_write(13, 32'hFFFF_FFFF);
      for (int a = 12; a < 16; a++) begin
         do_read(a, v); chk("R3 unmapped reads zero", v, 32'h0);
      end
      do_read(9, v); chk("R2 unmapped write ignored", v, 32'h0);

      // R10: read and write on the same edge
      do_rdwr(6, 32'h0000_003C, v); chk("R10 read sees old", v, 32'h0);
      do_read(6, v); chk("R10 write landed", v, 32'h0000_003C);

      // Random traffic checked by the reference model every cycle
      for (int i = 0; i < 2000; i++) begin
         @(negedge clk);
         wr_en = ($urandom % 3) == 0;
         rd_en = ($urandom % 2) == 0;
         addr  = 4'($urandom % 16);
         wdata = $urandom;
         if (($urandom % 4) == 0) pad_in = $urandom;
         if (($urandom % 5) == 0) begin alt_out = $urandom; alt_oe = $urandom; end
      end
      @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

endmodule